// File: doc/BRIEF.md
# Prescaled Sixteen-Bit Timer with Eight Event Channels

The block is a free-running 16-bit counter that advances once per prescaler tick. The tick comes from the bus clock divided by a power of two between 1 and 128. Eight channels share the counter. A channel in capture mode copies the counter value when its strobe input pulses. A channel in compare mode raises a one-cycle event pulse when the counter reaches the value held in its register. Every capture or match sets a sticky per-channel flag. A host clears the flag by writing a one to it or, if fast clearing is enabled, as a side effect of touching that channel's register.

A small byte-wide register bus gives access to all of it. A change of division ratio is held back until the free-running prescale stage counter is about to roll over to all zeros, so the tick pattern never breaks in the middle of a period. A two-state controller handles this. In `PS_RUN` no change is waiting. A select write arriving on a cycle where the stage counter is all ones is applied at once and the controller stays in `PS_RUN`. A select write on any other cycle stores the code and moves to `PS_PEND`. In `PS_PEND`, a further write replaces the stored code. When the stage counter next reaches all ones, the stored code becomes active and the controller returns to `PS_RUN`.

The interrupt output is the OR over all channels of flag AND per-channel enable.

Top module: `prescaled_capture_timer`

## Requirements
- R1: After reset the active divide code is 0. Select code k (bits [2:0] of the control byte at address 0x00) produces exactly 128>>k counter ticks in any 128 consecutive clock cycles.
- R2: A written divide code becomes active only at a clock edge where all seven prescale stage bits are 1, that is, just before they all return to 0. Until then, the old ratio stays in force.
- R3: The counter adds one on each tick, holds between ticks, and wraps from 0xFFFF to 0x0000.
- R4: A strobe on a channel whose mode bit is 0 (capture) stores the counter value of that cycle in the channel register and sets the channel flag on the same edge.
- R5: A channel whose mode bit is 1 (compare; mode byte at 0x01, bit n for channel n) drives cmp_evt[n] high for exactly one cycle: the first cycle after a tick in which the counter equals the channel register. The flag is set on the next edge. A capture-mode channel never pulses cmp_evt.
- R6: The flag byte at 0x03 holds channel n in bit n and resets to 0x00. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R7: With the fast-clear bit set (bit 7 of the control byte), two accesses clear a channel's flag: a read of either byte of a capture-mode channel register, and a write of either byte of a compare-mode channel register. With the bit clear, neither access affects flags.
- R8: When a flag-setting event and any clear request reach the same channel in the same cycle, the flag ends at 1.
- R9: irq is 1 exactly when some flag bit and the same bit of the enable byte at 0x02 are both 1.
- R10: Register map: 0x04/0x05 read the counter high/low byte. Channel n occupies 0x10+2n (high byte) and 0x11+2n (low byte). Control, mode and enable bytes reset to 0x00 and read back as written (control unused bits read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe; its side effects act on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid while bus_rd is high, else 0 |
| cap_strobe | input | 8 | Per-channel capture pulse |
| cmp_evt | output | 8 | Per-channel one-cycle compare-match pulse |
| irq | output | 1 | Combined flag-and-enable interrupt |

## Verification
A wrong active divide code or a wrong controller state shows at the ports as a changed count rate. A window of 128 cycles always has a fixed tick count for each code, so the rate error is visible in at most two such windows. A mistake in flag bookkeeping shows on the next read of the flag byte or on irq in the following cycle. A compare that fires twice, too early or on a capture channel shows on cmp_evt in the very cycle it happens. Sweeping every divide code and every clearing path gives each fault a port-level symptom within a few hundred cycles. The exception is the wrap, which takes one full counter period.

// File: rtl/pct_pkg.sv
package pct_pkg;

    // Divide-code change controller states
    typedef enum logic [0:0] {
        PS_RUN  = 1'b0,
        PS_PEND = 1'b1
    } ps_state_t;

    // Register byte addresses
    localparam int A_CTRL  = 'h00;
    localparam int A_MODE  = 'h01;
    localparam int A_IEN   = 'h02;
    localparam int A_FLAG  = 'h03;
    localparam int A_CNTH  = 'h04;
    localparam int A_CNTL  = 'h05;
    localparam int CH_BASE = 'h10;

    // Control byte field positions
    localparam int FCEN_BIT = 7;

endpackage

// File: rtl/pct_prescaler.sv
module pct_prescaler
    import pct_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel_wr,
    input  logic [SEL_W-1:0]            sel_new,
    output logic                        tick,
    output logic [SEL_W-1:0]            act_sel,
    output logic [(1<<SEL_W)-2:0]       stage
);

    localparam int STG_W = (1 << SEL_W) - 1;

    ps_state_t          state_q, state_d;
    logic [SEL_W-1:0]   pend_q, pend_d;
    logic [SEL_W-1:0]   act_q, act_d;
    logic [STG_W-1:0]   stage_q;
    logic [STG_W-1:0]   mask;
    logic               aligned;

    assign aligned = &stage_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            pend_q  <= '0;
            act_q   <= '0;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            act_q   <= act_d;
            stage_q <= stage_q + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        act_d   = act_q;
        unique case (state_q)
            PS_RUN: begin
                if (sel_wr) begin
                    if (aligned) begin
                        act_d = sel_new;
                    end else begin
                        pend_d  = sel_new;
                        state_d = PS_PEND;
                    end
                end
            end
            PS_PEND: begin
                if (sel_wr) begin
                    pend_d = sel_new;
                end
                if (aligned) begin
                    act_d   = sel_wr ? sel_new : pend_q;
                    state_d = PS_RUN;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        mask    = (STG_W'(1) << act_q) - 1'b1;
        tick    = &(stage_q | ~mask);
        act_sel = act_q;
        stage   = stage_q;
    end

endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             fresh
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            fresh <= 1'b0;
        end else begin
            fresh <= tick;
            if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pct_channel.sv
module pct_channel #(
    parameter int CNT_W = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fresh,
    input  logic             oc_mode,
    input  logic             cap_strobe,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [DW-1:0]    wdata,
    input  logic             clr_req,
    output logic [CNT_W-1:0] val,
    output logic             flag,
    output logic             cmp_evt,
    output logic             set_evt
);

    localparam int HI_W = CNT_W - DW;

    logic cap_evt;

    assign cap_evt = cap_strobe && !oc_mode;
    assign cmp_evt = fresh && oc_mode && (cnt == val);
    assign set_evt = cap_evt || cmp_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (cap_evt) begin
            val <= cnt;
        end else begin
            if (wr_hi) val[CNT_W-1:DW] <= wdata[HI_W-1:0];
            if (wr_lo) val[DW-1:0]     <= wdata;
        end
    end

    // Set has priority over any clear source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/prescaled_capture_timer.sv
module prescaled_capture_timer
    import pct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3,
    parameter int AW    = 6,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] cap_strobe,
    output logic [DW-1:0] cmp_evt,
    output logic          irq
);

    localparam int NCH   = DW;
    localparam int STG_W = (1 << SEL_W) - 1;
    localparam int PAD_W = DW - 1 - SEL_W;

    // Register file
    logic [SEL_W-1:0] req_sel;
    logic             fcen;
    logic [NCH-1:0]   oc_mode;
    logic [NCH-1:0]   ien;

    // Internal wiring
    logic             tick;
    logic             fresh;
    logic [SEL_W-1:0] act_sel;
    logic [STG_W-1:0] stage;
    logic [CNT_W-1:0] cnt;
    logic [NCH-1:0]   flags;
    logic [NCH-1:0]   set_vec;
    logic [NCH-1:0]   clr_req;
    logic [NCH-1:0]   hit_hi;
    logic [NCH-1:0]   hit_lo;
    logic [CNT_W-1:0] ch_val [NCH];

    logic wr_ctrl, wr_mode, wr_ien, wr_flag;

    assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));
    assign wr_mode = bus_wr && (bus_addr == AW'(A_MODE));
    assign wr_ien  = bus_wr && (bus_addr == AW'(A_IEN));
    assign wr_flag = bus_wr && (bus_addr == AW'(A_FLAG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sel <= '0;
            fcen    <= 1'b0;
            oc_mode <= '0;
            ien     <= '0;
        end else begin
            if (wr_ctrl) begin
                req_sel <= bus_wdata[SEL_W-1:0];
                fcen    <= bus_wdata[FCEN_BIT];
            end
            if (wr_mode) oc_mode <= bus_wdata;
            if (wr_ien)  ien     <= bus_wdata;
        end
    end

    pct_prescaler #(
        .SEL_W (SEL_W)
    ) i_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (wr_ctrl),
        .sel_new (bus_wdata[SEL_W-1:0]),
        .tick    (tick),
        .act_sel (act_sel),
        .stage   (stage)
    );

    pct_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (cnt),
        .fresh (fresh)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign hit_hi[n] = (bus_addr == AW'(CH_BASE + 2*n));
        assign hit_lo[n] = (bus_addr == AW'(CH_BASE + 2*n + 1));

        assign clr_req[n] = (wr_flag && bus_wdata[n])
                         || (fcen && (hit_hi[n] || hit_lo[n])
                             && ((bus_rd && !oc_mode[n]) || (bus_wr && oc_mode[n])));

        pct_channel #(
            .CNT_W (CNT_W),
            .DW    (DW)
        ) i_channel (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt        (cnt),
            .fresh      (fresh),
            .oc_mode    (oc_mode[n]),
            .cap_strobe (cap_strobe[n]),
            .wr_hi      (bus_wr && hit_hi[n]),
            .wr_lo      (bus_wr && hit_lo[n]),
            .wdata      (bus_wdata),
            .clr_req    (clr_req[n]),
            .val        (ch_val[n]),
            .flag       (flags[n]),
            .cmp_evt    (cmp_evt[n]),
            .set_evt    (set_vec[n])
        );
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                AW'(A_CTRL): bus_rdata = {fcen, {PAD_W{1'b0}}, req_sel};
                AW'(A_MODE): bus_rdata = oc_mode;
                AW'(A_IEN):  bus_rdata = ien;
                AW'(A_FLAG): bus_rdata = flags;
                AW'(A_CNTH): bus_rdata = DW'(cnt[CNT_W-1:DW]);
                AW'(A_CNTL): bus_rdata = cnt[DW-1:0];
                default: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (hit_hi[n]) bus_rdata = bus_rdata | DW'(ch_val[n][CNT_W-1:DW]);
                        if (hit_lo[n]) bus_rdata = bus_rdata | ch_val[n][DW-1:0];
                    end
                end
            endcase
        end
    end

    assign irq = |(flags & ien);

endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
    parameter int CNT_W = 16,
    parameter int NCH   = 8,
    parameter int SEL_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic [(1<<SEL_W)-2:0] stage,
    input logic [SEL_W-1:0]      act_sel,
    input logic [CNT_W-1:0]      cnt,
    input logic [NCH-1:0]        cap_strobe,
    input logic [NCH-1:0]        oc_mode,
    input logic [NCH-1:0]        flags,
    input logic [NCH-1:0]        set_vec,
    input logic [NCH-1:0]        cmp_evt
);

    // R2: the active code only changes on the edge that leaves the all-ones stage
    p_sel_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |-> (&$past(stage)));

    // R3: one step per tick, wrapping
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R3: no movement without a tick
    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R4: capture strobe sets the flag
    p_cap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cap_strobe & ~oc_mode)) |=>
            ((flags & $past(cap_strobe & ~oc_mode)) == $past(cap_strobe & ~oc_mode)));

    // R5: compare pulse sets the flag
    p_cmp_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmp_evt) |=> ((flags & $past(cmp_evt)) == $past(cmp_evt)));

    // R5: capture-mode channels never pulse
    p_cmp_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_evt & ~oc_mode) == '0));

    // R6: a flag never rises without an event
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

endmodule

bind prescaled_capture_timer pct_checker #(
    .CNT_W (CNT_W),
    .NCH   (NCH),
    .SEL_W (SEL_W)
) i_pct_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .stage      (stage),
    .act_sel    (act_sel),
    .cnt        (cnt),
    .cap_strobe (cap_strobe),
    .oc_mode    (oc_mode),
    .flags      (flags),
    .set_vec    (set_vec),
    .cmp_evt    (cmp_evt)
);

// File: tb/test_prescaled_capture_timer.sv
`timescale 1ns/1ps
module test_prescaled_capture_timer;

    localparam int A_CTRL = 'h00, A_MODE = 'h01, A_IEN = 'h02, A_FLAG = 'h03;
    localparam int A_CNTH = 'h04, A_CNTL = 'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] cap_strobe = '0;
    logic [7:0] cmp_evt;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    prescaled_capture_timer i_prescaled_capture_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cap_strobe (cap_strobe),
        .cmp_evt    (cmp_evt),
        .irq        (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = a[5:0]; bus_wdata = d[7:0]; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = a[5:0]; bus_rd = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Ticks seen over 'span' clock edges, from the counter low byte
    task automatic measure(input int span, output int d);
        int a, b;
        rd(A_CNTL, a);
        repeat (span - 1) @(negedge clk);
        rd(A_CNTL, b);
        d = (b - a) & 255;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, h, l, d, tgt, evts;
        bit found;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6, R10, R9: reset state
        rd(A_FLAG, v); chk("R6 reset flags", v, 0);
        rd(A_CTRL, v); chk("R10 reset ctrl", v, 0);
        rd(A_MODE, v); chk("R10 reset mode", v, 0);
        rd(A_IEN, v);  chk("R10 reset ien", v, 0);
        chk("R9 reset irq", int'(irq), 0);
        chk("R5 reset cmp_evt", int'(cmp_evt), 0);

        // R2: code written mid-period leaves divide-by-1 in force
        while (cyc % 128 != 10) @(negedge clk);
        wr(A_CTRL, 3);
        measure(32, d); chk("R2 old ratio before align", d, 32);
        while (cyc % 128 != 0) @(negedge clk);
        measure(64, d); chk("R2 new ratio after align", d, 8);
        rd(A_CTRL, v); chk("R10 ctrl readback", v, 3);

        // R1: sweep every divide code
        for (int k = 0; k < 8; k++) begin
            wr(A_CTRL, k);
            repeat (200) @(negedge clk);
            measure(128, d);
            chk($sformatf("R1 divide code %0d", k), d, 128 >> k);
        end

        // R5, R9, R7: compare at divide-by-128
        while (cyc % 128 != 5) @(negedge clk);
        rd(A_CNTH, h); rd(A_CNTL, l);
        tgt = (((h << 8) | l) + 2) & 'hFFFF;
        wr(A_MODE, 'h40);
        wr('h1C, tgt >> 8);
        wr('h1D, tgt & 'hFF);
        wr(A_IEN, 'h40);
        chk("R9 irq low without flag", int'(irq), 0);
        evts = 0;
        for (int i = 0; i < 400; i++) begin
            if (cmp_evt[6]) evts++;
            @(negedge clk);
        end
        chk("R5 single compare pulse", evts, 1);
        rd(A_FLAG, v); chk("R5 compare flag", v, 'h40);
        chk("R9 irq with enabled flag", int'(irq), 1);
        wr(A_CTRL, 'h87);
        wr('h1D, tgt & 'hFF);
        rd(A_FLAG, v); chk("R7 write clears compare flag", v, 0);
        chk("R9 irq after clear", int'(irq), 0);

        // R4: capture at divide-by-1
        wr(A_CTRL, 0);
        repeat (200) @(negedge clk);
        bus_addr = 6'(A_CNTH); bus_rd = 1'b1; cap_strobe = 8'h04;
        #1 h = int'(bus_rdata);
        @(negedge clk);
        bus_addr = 6'(A_CNTL); cap_strobe = 8'h08;
        #1 l = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0; cap_strobe = 8'h00;
        rd('h14, v); chk("R4 capture high byte", v, h);
        rd('h17, v); chk("R4 capture low byte", v, l);
        rd(A_FLAG, v); chk("R4 R7 flags after capture, no fast clear", v, 'h0C);

        // R6: write-one clear, write-zero no effect
        wr(A_FLAG, 'h04);
        rd(A_FLAG, v); chk("R6 write one clears", v, 'h08);
        wr(A_FLAG, 'h00);
        rd(A_FLAG, v); chk("R6 write zero ignored", v, 'h08);

        // R7: fast clear on capture-channel read
        wr(A_CTRL, 'h80);
        rd('h17, v);
        rd(A_FLAG, v); chk("R7 read clears capture flag", v, 0);

        // R8: set beats write-one clear
        bus_addr = 6'(A_FLAG); bus_wdata = 8'h20; bus_wr = 1'b1; cap_strobe = 8'h20;
        @(negedge clk);
        bus_wr = 1'b0; cap_strobe = 8'h00;
        rd(A_FLAG, v); chk("R8 set wins over write clear", v, 'h20);
        wr(A_FLAG, 'h20);
        rd(A_FLAG, v); chk("R6 flag cleared", v, 0);

        // R8: set beats fast-clear read
        bus_addr = 6'h1A; bus_rd = 1'b1; cap_strobe = 8'h20;
        @(negedge clk);
        bus_rd = 1'b0; cap_strobe = 8'h00;
        rd(A_FLAG, v); chk("R8 set wins over read clear", v, 'h20);
        chk("R9 masked flag keeps irq low", int'(irq), 0);
        wr(A_FLAG, 'h20);

        // R3: wrap, seen as a compare at 0x0000
        wr(A_MODE, 'h41);
        wr('h10, 0);
        wr('h11, 0);
        found = 1'b0;
        for (int i = 0; i < 70000 && !found; i++) begin
            bus_addr = 6'(A_CNTL); bus_rd = 1'b1;
            #1;
            if (cmp_evt[0]) begin
                found = 1'b1;
                chk("R3 counter low byte at wrap", int'(bus_rdata), 0);
            end
            @(negedge clk);
        end
        bus_rd = 1'b0;
        chk("R3 wrap reached", int'(found), 1);
        rd(A_FLAG, v); chk("R5 wrap compare flag", v, 'h01);
        chk("R9 irq masked for channel 0", int'(irq), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule